// File: doc/BRIEF.md
# ADC Register Front End with Coherent Result Readout

This block is the digital side of a 10-bit successive-approximation converter. Software reaches it over a plain byte-wide register bus: an address, a read strobe, a write strobe, write data and combinational read data. A single control/status byte selects one of sixteen input channels, carries two timing options that are passed straight to the analog engine, and powers the converter on or off. Read-only bit 7 of that byte reports that a fresh result is waiting. While the converter is powered and the chip is not halted, the block starts conversions back to back. Each finished result is latched into a pair of byte registers. Writing a different channel in the middle of a conversion abandons it and starts over on the new input.

A 10-bit result does not fit in one byte, so software reads it as two bytes. Reading the low byte freezes both bytes. The freeze lasts until the high byte is read or the converter is switched off, so the two bytes always belong to the same sample. A result that finishes during the freeze is held aside, and only the newest one is kept. It is moved into the byte registers when the freeze ends. Halt mode cuts power to the converter. After halt ends, a settling counter of configurable length must run out before any conversion may start. Wait mode leaves the block untouched, so it has no pin. The block raises no interrupts.

Top module: `adc_front_regs`

## Requirements
- R1: After reset, the control byte (address 0), the high data byte (address 1) and the low data byte (address 2) all read 00h, the converter is unpowered, and no conversion start is issued.
- R2: Bit layout of the control byte: 7 = result-ready (read-only, writes to it are ignored), 6 = speed, 5 = enable, 4 = slow, 3:0 = channel. Bits 6:0 read back exactly as written, and the speed, slow and channel bits drive the matching converter outputs.
- R3: While enabled and not halted, conversions run continuously. Each accepted result sets the ready bit. The result appears with bits 9:2 in the high byte, and bits 1:0 in bits 1:0 of the low byte with the upper six bits zero.
- R4: Reading the high byte clears the ready bit, unless a new result is loaded on that same cycle.
- R5: Writing a different channel value while a conversion is allowed clears the ready bit and issues a new start on the next cycle. The result of the abandoned conversion is never exposed, so the next ready result comes from the new channel.
- R6: Reading the low byte freezes both data bytes. Results that arrive while the freeze holds do not change either byte.
- R7: Reading the high byte ends the freeze. The newest result that arrived during the freeze, if any, is then moved into the data bytes and sets the ready bit.
- R8: Clearing the enable bit removes converter power, stops issuing starts and ends any freeze.
- R9: While halt is asserted the converter is unpowered and no start is issued. After halt is released, the first start appears on the clock edge STAB_CYC+1 edges after the release edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address (0 control, 1 data high, 2 data low) |
| bus_rd | input | 1 | Read strobe; side effects take place on the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| halt_mode | input | 1 | Chip halt mode request |
| conv_pwr | output | 1 | Converter power enable |
| conv_start | output | 1 | One-cycle start (or restart) of a conversion |
| conv_chan | output | 4 | Channel to convert |
| conv_speed | output | 1 | Speed option for the analog engine |
| conv_slow | output | 1 | Slow option for the analog engine |
| conv_done | input | 1 | One-cycle pulse: result valid |
| conv_result | input | RES_W | Conversion result |

## Verification
Most internal faults in this block show up as a mismatch between the two data bytes or as a stale ready bit. A freeze that releases too early, or a held-aside result that is lost, produces a high byte that does not match the low byte read one or two cycles earlier. A restart that lets the abandoned result through shows the old channel in the top nibble of the next high byte, within one conversion latency. Faults in the settling counter or the power gating shift the first start pulse by a countable number of edges after halt is released, so the bench counts those edges exactly rather than waiting loosely.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;

   localparam int BYTE_W = 8;
   localparam int CHAN_W = 4;

   // control byte bit positions (software decodes these)
   localparam int RDY_BIT  = 7;
   localparam int SPD_BIT  = 6;
   localparam int ENA_BIT  = 5;
   localparam int SLW_BIT  = 4;

   typedef enum logic [1:0] {
      SEL_CTL  = 2'd0,
      SEL_DHI  = 2'd1,
      SEL_DLO  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic              speed;
      logic              ena;
      logic              slow;
      logic [CHAN_W-1:0] chan;
   } ctl_fields_t;

endpackage

// File: rtl/adc_fe_ctl.sv
module adc_fe_ctl
   import adc_fe_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wdata,
   output ctl_fields_t       ctl,
   output logic              chan_chg
);

   ctl_fields_t ctl_q;
   logic        unused_rdy_wr;

   // the ready bit is read-only: its written value goes nowhere
   assign unused_rdy_wr = wdata[RDY_BIT];

   assign chan_chg = wr_en & (wdata[CHAN_W-1:0] != ctl_q.chan);
   assign ctl      = ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_en) begin
         ctl_q.speed <= wdata[SPD_BIT];
         ctl_q.ena   <= wdata[ENA_BIT];
         ctl_q.slow  <= wdata[SLW_BIT];
         ctl_q.chan  <= wdata[CHAN_W-1:0];
      end
   end

   // R2: a write takes effect on the following cycle, the ready bit excluded
   assert_ctl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ctl.chan == $past(wdata[CHAN_W-1:0]) && ctl.ena == $past(wdata[ENA_BIT])));

endmodule

// File: rtl/adc_fe_seq.sv
module adc_fe_seq #(
   parameter int STAB_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ena,
   input  logic halt,
   input  logic chan_chg,
   input  logic conv_done,
   output logic conv_pwr,
   output logic conv_start,
   output logic accept,
   output logic restart
);

   localparam int SW = $clog2(STAB_CYC + 1);

   if (STAB_CYC < 1) begin : g_bad_stab
      $error("adc_fe_seq: STAB_CYC must be at least 1");
   end

   logic [SW-1:0] stab_q;
   logic          busy_q, start_q;
   logic          power, run_ok;

   assign power      = ena & ~halt;
   assign run_ok     = power & (stab_q == '0);
   assign restart    = chan_chg & run_ok;
   // a done that coincides with a (re)start belongs to the abandoned conversion
   assign accept     = conv_done & busy_q & power & ~start_q & ~restart;
   assign conv_pwr   = power;
   assign conv_start = start_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stab_q <= '0;
      end else if (halt) begin
         stab_q <= SW'(STAB_CYC);
      end else if (stab_q != '0) begin
         stab_q <= stab_q - SW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         start_q <= 1'b0;
      end else if (!run_ok) begin
         busy_q  <= 1'b0;
         start_q <= 1'b0;
      end else if (restart) begin
         busy_q  <= 1'b1;
         start_q <= 1'b1;
      end else if (accept) begin
         busy_q  <= 1'b0;
         start_q <= 1'b0;
      end else if (!busy_q) begin
         busy_q  <= 1'b1;
         start_q <= 1'b1;
      end else begin
         start_q <= 1'b0;
      end
   end

   // R8: no start after a cycle without converter power
   assert_no_start_unpowered_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_pwr |=> !conv_start);

   // R9: settling window blocks every start
   assert_stab_blocks_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stab_q != '0) |=> !conv_start);

   // R5: a channel change while running always yields a start
   assert_restart_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> conv_start);

endmodule

// File: rtl/adc_fe_data.sv
module adc_fe_data #(
   parameter int RES_W   = 10,
   parameter bit PEND_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic [RES_W-1:0] result,
   input  logic             rd_lo,
   input  logic             rd_hi,
   input  logic             ena,
   input  logic             restart,
   output logic [RES_W-1:0] data,
   output logic             rdy
);

   logic             lock_q, lock_d, rdy_q;
   logic [RES_W-1:0] data_q;
   logic             pend_v;
   logic [RES_W-1:0] pend_val;
   logic             load_new, load_pend;

   // freeze starts on a low-byte read, ends on a high-byte read or power-off
   assign lock_d    = ena & (rd_lo | (lock_q & ~rd_hi));
   assign load_new  = accept & ~lock_d;
   assign load_pend = ~load_new & pend_v & ~lock_d;

   if (PEND_EN) begin : g_pend
      logic             pv_q;
      logic [RES_W-1:0] pd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pv_q <= 1'b0;
            pd_q <= '0;
         end else if (accept & lock_d) begin
            pv_q <= 1'b1;
            pd_q <= result;
         end else if (!lock_d) begin
            pv_q <= 1'b0;
         end
      end
      assign pend_v   = pv_q;
      assign pend_val = pd_q;
   end else begin : g_drop
      assign pend_v   = 1'b0;
      assign pend_val = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         lock_q <= 1'b0;
         rdy_q  <= 1'b0;
      end else begin
         lock_q <= lock_d;
         if (load_new) begin
            data_q <= result;
         end else if (load_pend) begin
            data_q <= pend_val;
         end
         if (restart) begin
            rdy_q <= 1'b0;
         end else if (load_new | load_pend) begin
            rdy_q <= 1'b1;
         end else if (rd_hi) begin
            rdy_q <= 1'b0;
         end
      end
   end

   assign data = data_q;
   assign rdy  = rdy_q;

   // R6: held freeze keeps both bytes still
   assert_freeze_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && !rd_hi && ena) |=> $stable(data));

   // R4: high-byte read with nothing new clears ready
   assert_hi_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hi && !accept && !pend_v && !restart) |=> !rdy);

   // R5: restart clears ready
   assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !rdy);

   // R7: release with a held result raises ready
   assert_pending_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && rd_hi && pend_v && !restart) |=> rdy);

endmodule

// File: rtl/adc_front_regs.sv
module adc_front_regs
   import adc_fe_pkg::*;
#(
   parameter int RES_W    = 10,
   parameter int STAB_CYC = 16,
   parameter bit PEND_EN  = 1'b1,
   parameter int ADDR_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              halt_mode,
   output logic              conv_pwr,
   output logic              conv_start,
   output logic [3:0]        conv_chan,
   output logic              conv_speed,
   output logic              conv_slow,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_result
);

   localparam int LO_W  = RES_W - BYTE_W;
   localparam int PAD_W = BYTE_W - LO_W;

   if (LO_W < 1 || LO_W > BYTE_W) begin : g_bad_res
      $error("adc_front_regs: RES_W must lie between 9 and 16");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("adc_front_regs: ADDR_W must be at least 2");
   end

   logic        page_ok;
   reg_sel_e    sel;
   ctl_fields_t ctl;
   logic        ctl_wr, rd_lo, rd_hi, chan_chg;
   logic        accept, restart, rdy;
   logic [RES_W-1:0] data;

   if (ADDR_W > 2) begin : g_page
      assign page_ok = ~|bus_addr[ADDR_W-1:2];
   end else begin : g_flat
      assign page_ok = 1'b1;
   end

   assign sel    = reg_sel_e'(bus_addr[1:0]);
   assign ctl_wr = bus_wr & page_ok & (sel == SEL_CTL);
   assign rd_lo  = bus_rd & page_ok & (sel == SEL_DLO);
   assign rd_hi  = bus_rd & page_ok & (sel == SEL_DHI);

   adc_fe_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ctl_wr),
      .wdata    (bus_wdata),
      .ctl      (ctl),
      .chan_chg (chan_chg)
   );

   adc_fe_seq #(.STAB_CYC(STAB_CYC)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .ena        (ctl.ena),
      .halt       (halt_mode),
      .chan_chg   (chan_chg),
      .conv_done  (conv_done),
      .conv_pwr   (conv_pwr),
      .conv_start (conv_start),
      .accept     (accept),
      .restart    (restart)
   );

   adc_fe_data #(.RES_W(RES_W), .PEND_EN(PEND_EN)) u_data (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .result  (conv_result),
      .rd_lo   (rd_lo),
      .rd_hi   (rd_hi),
      .ena     (ctl.ena),
      .restart (restart),
      .data    (data),
      .rdy     (rdy)
   );

   assign conv_chan  = ctl.chan;
   assign conv_speed = ctl.speed;
   assign conv_slow  = ctl.slow;

   always_comb begin
      bus_rdata = '0;
      if (page_ok) begin
         unique case (sel)
            SEL_CTL:  bus_rdata = {rdy, ctl.speed, ctl.ena, ctl.slow, ctl.chan};
            SEL_DHI:  bus_rdata = data[RES_W-1 -: BYTE_W];
            SEL_DLO:  bus_rdata = {{PAD_W{1'b0}}, data[LO_W-1:0]};
            default:  bus_rdata = '0;
         endcase
      end
   end

   // R3: power follows enable and halt at the ports
   assert_power_gating_R3: assert property (@(posedge clk) disable iff (!rst_n)
      conv_pwr == (ctl.ena && !halt_mode));

endmodule

// File: tb/adc_front_regs_tb.sv
module adc_front_regs_tb;

   localparam int CLK_PER  = 10;
   localparam int LAT      = 6;
   localparam int STAB     = 16;

   // table: {speed, slow, channel}
   localparam logic [5:0] VEC [4] = '{6'b10_0011, 6'b01_1100, 6'b11_0000, 6'b00_1111};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       halt_mode = 1'b0;
   logic       conv_pwr, conv_start, conv_speed, conv_slow;
   logic [3:0] conv_chan;
   logic       conv_done = 1'b0;
   logic [9:0] conv_result = '0;

   int n_chk = 0, n_fail = 0;

   always #(CLK_PER/2) clk = ~clk;

   adc_front_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .halt_mode(halt_mode),
      .conv_pwr(conv_pwr), .conv_start(conv_start), .conv_chan(conv_chan),
      .conv_speed(conv_speed), .conv_slow(conv_slow), .conv_done(conv_done),
      .conv_result(conv_result)
   );

   // behavioural conversion engine: result = {channel, running sample count}
   int         cnt = 0;
   logic [3:0] st_chan = '0;
   logic [5:0] sample = '0;
   logic [9:0] last_acc = '0;
   logic [3:0] shadow_ch = '0;
   logic       restart_m;

   assign restart_m = bus_wr && bus_addr == 2'd0 && bus_wdata[3:0] != shadow_ch && conv_pwr;

   always @(posedge clk) begin
      if (!rst_n || !conv_pwr) begin
         cnt <= 0;
         conv_done <= 1'b0;
      end else if (conv_start) begin
         cnt <= LAT;
         st_chan <= conv_chan;
         conv_done <= 1'b0;
      end else if (cnt != 0) begin
         cnt <= cnt - 1;
         if (cnt == 1) begin
            conv_done <= 1'b1;
            conv_result <= {st_chan, sample};
            sample <= sample + 6'd1;
         end
      end else begin
         conv_done <= 1'b0;
      end
      if (rst_n && conv_done && conv_pwr && !conv_start && !restart_m)
         last_acc <= conv_result;
      if (bus_wr && bus_addr == 2'd0)
         shadow_ch <= bus_wdata[3:0];
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d, output logic [9:0] snap);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      d = bus_rdata; snap = last_acc;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic bus_write(input logic [7:0] v);
      @(negedge clk);
      bus_addr = 2'd0; bus_wdata = v; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic wait_rdy(input string req);
      logic [7:0] d;
      logic [9:0] s;
      bit seen = 1'b0;
      for (int i = 0; i < 200 && !seen; i++) begin
         bus_read(2'd0, d, s);
         seen = d[7];
      end
      check(seen, req, 0, 1);
   endtask

   logic [7:0] rd, hi, lo;
   logic [9:0] snap, snap2, held;

   initial begin
      int k;
      bit gap_ok;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      bus_read(2'd0, rd, snap); check(rd == 8'h00, "R1 ctl", rd, 0);
      bus_read(2'd1, rd, snap); check(rd == 8'h00, "R1 dhi", rd, 0);
      bus_read(2'd2, rd, snap); check(rd == 8'h00, "R1 dlo", rd, 0);
      check(!conv_pwr && !conv_start, "R1 idle", {conv_pwr, conv_start}, 0);
      // R2 ready bit read-only, enable left off
      bus_write(8'hDF);
      bus_read(2'd0, rd, snap); check(rd == 8'h5F, "R2 readback", rd, 8'h5F);
      check(conv_chan == 4'hF && conv_speed && conv_slow, "R2 outputs",
            {conv_speed, conv_slow, conv_chan}, 6'h3F);

      // table-driven pass: R2, R3, R5
      foreach (VEC[i]) begin
         logic [7:0] w;
         w = {1'b0, VEC[i][5], 1'b1, VEC[i][4], VEC[i][3:0]};
         bus_write(w);
         wait_rdy("R3 ready");
         bus_read(2'd0, rd, snap);
         check(rd[6:0] == w[6:0], "R2 table readback", rd[6:0], w[6:0]);
         check(conv_chan == VEC[i][3:0] && conv_speed == VEC[i][5] && conv_slow == VEC[i][4],
               "R2 table outputs", {conv_speed, conv_slow, conv_chan}, VEC[i]);
         bus_read(2'd2, lo, snap);
         bus_read(2'd1, hi, snap2);
         check({hi, lo[1:0]} == snap, "R3 split result", {hi, lo[1:0]}, snap);
         check(lo[7:2] == 6'd0, "R3 low pad", lo, lo[1:0]);
         check(hi[7:4] == VEC[i][3:0], "R5 channel in result", hi[7:4], VEC[i][3:0]);
      end

      // R5 abort mid-conversion
      bus_write(8'h22);
      @(negedge clk);
      while (!conv_start) @(negedge clk);
      repeat (3) @(negedge clk);
      bus_write(8'h29);
      check(conv_start == 1'b1, "R5 restart pulse", conv_start, 1);
      bus_read(2'd0, rd, snap); check(rd[7] == 1'b0, "R5 ready cleared", rd[7], 0);
      wait_rdy("R5 ready after restart");
      bus_read(2'd2, lo, snap);
      bus_read(2'd1, hi, snap2);
      check(hi[7:4] == 4'h9, "R5 new channel", hi[7:4], 9);

      // R6 / R7 freeze and held result
      bus_write(8'h25);
      wait_rdy("R6 ready");
      bus_read(2'd2, lo, held);
      repeat (40) @(negedge clk);
      bus_read(2'd1, hi, snap);
      check({hi, lo[1:0]} == held, "R6 frozen pair", {hi, lo[1:0]}, held);
      bus_read(2'd0, rd, snap); check(rd[7] == 1'b1, "R7 ready after release", rd[7], 1);
      bus_read(2'd2, lo, snap);
      bus_read(2'd1, hi, snap2);
      check({hi, lo[1:0]} == snap, "R7 newest held result", {hi, lo[1:0]}, snap);
      check(snap != held, "R7 newer than frozen", snap, held);

      // R8 power-off ends the freeze and moves the held result in
      wait_rdy("R8 ready");
      bus_read(2'd2, lo, held);
      repeat (30) @(negedge clk);
      bus_write(8'h05);
      @(negedge clk);
      snap2 = last_acc;
      bus_read(2'd1, hi, snap);
      check(hi == snap2[9:2], "R8 release on disable", hi, snap2[9:2]);
      bus_read(2'd2, lo, snap);
      check(lo[1:0] == snap2[1:0], "R8 low byte after release", lo, snap2[1:0]);
      gap_ok = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (conv_start || conv_pwr) gap_ok = 1'b0;
      end
      check(gap_ok, "R8 no power no start", gap_ok, 1);

      // R4 high read clears ready (no conversions running)
      bus_write(8'h25);
      wait_rdy("R4 ready");
      bus_write(8'h05);
      bus_read(2'd0, rd, snap); check(rd[7] == 1'b1, "R4 ready kept when disabled", rd[7], 1);
      bus_read(2'd1, hi, snap);
      bus_read(2'd0, rd, snap); check(rd[7] == 1'b0, "R4 ready cleared", rd[7], 0);

      // R9 halt and settling
      bus_write(8'h25);
      repeat (10) @(negedge clk);
      halt_mode = 1'b1;
      repeat (2) @(negedge clk);
      gap_ok = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (conv_start || conv_pwr) gap_ok = 1'b0;
      end
      check(gap_ok, "R9 halted", gap_ok, 1);
      halt_mode = 1'b0;
      k = 0;
      for (int i = 1; i <= STAB + 5 && k == 0; i++) begin
         @(negedge clk);
         if (conv_start) k = i;
      end
      check(k == STAB + 1, "R9 settling length", k, STAB + 1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PER * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule